// File: doc/BRIEF.md
# Buffer Descriptor List Manager

This block keeps track of the buffer descriptor lists that software has handed to a multi-line synchronous communications controller. Each line has a receive side and a transmit side, and each side holds a queue of up to two list addresses. The head of each queue is the list the data engine is currently working on. A command carries an 18-bit list address, a direction flag and two control bits: a kill bit and a buffer-enable bit. The command either appends a list, flushes the queue, or flushes the queue and then installs a new list.

A kill asks the line to recover at once. A receive kill sends the receiver back to hunting for sync characters (character-count framing) or for flags (bit-stuffing framing). A transmit kill returns the line to mark hold, and in bit-stuffing framing it sends an abort first. The action goes out on a one-cycle pulse, and the completion of the kill is then posted on the status channel. Refused commands are also reported on the status channel, with an error code. When the data engine reports that it has finished a list, the block pops that list and the next one becomes current.

Commands are handled by a state machine with six states. ST_IDLE accepts a command and moves to ST_EVAL. ST_EVAL goes to ST_REJECT if the address is odd or the queue is full, to ST_FLUSH on a kill, and to ST_ASSIGN otherwise. ST_FLUSH goes to ST_ASSIGN when buffer enable is set and to ST_REPORT when it is clear. ST_ASSIGN goes to ST_REPORT for a kill and to ST_IDLE for a plain append. ST_REJECT and ST_REPORT both return to ST_IDLE.

Top module: `bdl_list_mgr`

## Requirements
- R1: The list address is {cmd_hibyte[7:6], cmd_word0[15:0]}, 18 bits wide. Bits 17:16 come from bits 7:6 of the high byte.
- R2: With the kill bit (cmd_hibyte bit 4) clear, the command appends the address to the queue selected by cmd_rx (1 = receive, 0 = transmit). The buffer-enable bit (cmd_hibyte bit 5) has no effect in this case. If the queue was empty, the new address becomes the current address.
- R3: Each queue holds at most two lists. An append to a full queue leaves the queue unchanged and reports status code 2.
- R4: A command that would install an address with bit 0 set is refused with status code 3. It changes no queue and produces no action pulse, even when the kill bit is set.
- R5: Kill set with buffer enable clear empties the addressed queue. The address is ignored, and the other direction of the same line is untouched.
- R6: Kill and buffer enable both set empty the addressed queue and then install the new address as its only entry.
- R7: A receive kill pulses act_valid for one cycle. act_kind is 0 (sync hunt) when the line's line_bitstuff bit is 0, and 1 (flag hunt) when it is 1.
- R8: A transmit kill pulses act_valid with act_kind 2 (mark hold) when line_bitstuff is 0, and 3 (abort, then mark hold) when it is 1.
- R9: Each completed kill raises stat_valid for one cycle with stat_code 1 and the command's line and direction. This comes one or two cycles after the action pulse.
- R10: A done_valid pulse removes the head of the named queue. The second entry is the current address from the next cycle on. A done on an empty queue changes nothing.
- R11: After reset, every queue is empty, cmd_ready is 1, and neither act_valid nor stat_valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is 1 |
| cmd_ready | output | 1 | State machine is idle |
| cmd_line | input | LINE_W | Line addressed by the command |
| cmd_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cmd_word0 | input | 16 | Low 16 bits of the list address |
| cmd_hibyte | input | 8 | Address bits 17:16 at [7:6], buffer enable at [5], kill at [4] |
| line_bitstuff | input | NUM_LINES | Per-line framing: 1 bit-stuffing, 0 character-count |
| done_valid | input | 1 | Data engine finished its current list |
| done_line | input | LINE_W | Line of the finished list |
| done_rx | input | 1 | Direction of the finished list |
| sel_line | input | LINE_W | Line whose queue state is shown |
| rx_count | output | 2 | Receive lists queued on sel_line |
| rx_cur_addr | output | 18 | Current receive list address of sel_line |
| tx_count | output | 2 | Transmit lists queued on sel_line |
| tx_cur_addr | output | 18 | Current transmit list address of sel_line |
| act_valid | output | 1 | Kill action pulse |
| act_line | output | LINE_W | Line for the action |
| act_rx | output | 1 | Direction for the action |
| act_kind | output | 2 | 0 sync hunt, 1 flag hunt, 2 mark hold, 3 abort then mark |
| stat_valid | output | 1 | Status pulse |
| stat_line | output | LINE_W | Line for the status |
| stat_rx | output | 1 | Direction for the status |
| stat_code | output | 2 | 1 kill done, 2 queue full, 3 odd address |

## Verification
The pop property assumes that sel_line does not change across the cycle it checks. It also assumes that no append to the same queue lands in the cycle after a done arrives while the machine is idle. That holds because an accepted command reaches ST_ASSIGN two cycles later. The bench only raises done_valid when the machine is idle and no command is pending, and it changes sel_line only between commands. As a result, every pop it makes is seen on a stable queue.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    localparam int LIST_AW   = 18;
    localparam int KILL_POS  = 4;
    localparam int BEN_POS   = 5;
    localparam int QCNT_W    = 2;
    localparam logic [QCNT_W-1:0] QUEUE_CAP = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FLUSH,
        ST_ASSIGN,
        ST_REJECT,
        ST_REPORT
    } fsm_state_t;

    typedef enum logic [1:0] {
        STAT_NONE       = 2'd0,
        STAT_KILL_DONE  = 2'd1,
        STAT_QUEUE_FULL = 2'd2,
        STAT_ODD_ADDR   = 2'd3
    } stat_code_t;

    typedef enum logic [1:0] {
        ACT_SYNC_HUNT  = 2'd0,
        ACT_FLAG_HUNT  = 2'd1,
        ACT_MARK_HOLD  = 2'd2,
        ACT_ABORT_MARK = 2'd3
    } kill_act_t;

    typedef struct packed {
        logic [LIST_AW-1:0] addr;
        logic               kill;
        logic               ben;
        logic               rx;
    } bdl_cmd_t;

    function automatic logic [LIST_AW-1:0] build_list_addr(
        input logic [15:0] w0,
        input logic [7:0]  hb
    );
        return {hb[7:6], w0};
    endfunction

    function automatic kill_act_t pick_action(input logic rx, input logic bitstuff);
        if (rx) return bitstuff ? ACT_FLAG_HUNT : ACT_SYNC_HUNT;
        return bitstuff ? ACT_ABORT_MARK : ACT_MARK_HOLD;
    endfunction

endpackage

// File: rtl/bdl_queue.sv
module bdl_queue
    import bdl_pkg::*;
#(
    parameter int AW = LIST_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic              pop,
    output logic [QCNT_W-1:0] count,
    output logic [AW-1:0]     head
);

    logic [AW-1:0]     slot0_q, slot1_q, slot0_d, slot1_d;
    logic [QCNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        slot0_d = slot0_q;
        slot1_d = slot1_q;
        cnt_d   = cnt_q;
        if (flush) begin
            slot0_d = '0;
            slot1_d = '0;
            cnt_d   = '0;
        end else begin
            if (pop && cnt_d != '0) begin
                slot0_d = slot1_d;
                slot1_d = '0;
                cnt_d   = cnt_d - 1'b1;
            end
            if (push && cnt_d != QUEUE_CAP) begin
                if (cnt_d == '0) slot0_d = push_addr;
                else             slot1_d = push_addr;
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
            cnt_q   <= '0;
        end else begin
            slot0_q <= slot0_d;
            slot1_q <= slot1_d;
            cnt_q   <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign head  = slot0_q;

endmodule

// File: rtl/bdl_cmd_fsm.sv
module bdl_cmd_fsm
    import bdl_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic              cmd_rx,
    input  logic [15:0]       cmd_word0,
    input  logic [7:0]        cmd_hibyte,
    input  logic [QCNT_W-1:0] tgt_count,
    input  logic              tgt_bitstuff,
    output logic              cmd_ready,
    output logic [LINE_W-1:0] lat_line,
    output logic              lat_rx,
    output logic              q_flush,
    output logic              q_push,
    output logic [LIST_AW-1:0] q_addr,
    output logic              act_valid,
    output kill_act_t         act_kind,
    output logic              stat_valid,
    output stat_code_t        stat_code
);

    fsm_state_t  state_q, state_d;
    bdl_cmd_t    cmd_q;
    logic [LINE_W-1:0] line_q;
    stat_code_t  rej_q, rej_d;
    logic        needs_addr;
    logic [3:0]  unused_hib;

    assign unused_hib = cmd_hibyte[3:0];
    assign needs_addr = !cmd_q.kill || cmd_q.ben;

    // next-state logic
    always_comb begin
        state_d = state_q;
        rej_d   = rej_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (needs_addr && cmd_q.addr[0]) begin
                    state_d = ST_REJECT;
                    rej_d   = STAT_ODD_ADDR;
                end else if (cmd_q.kill) begin
                    state_d = ST_FLUSH;
                end else if (tgt_count == QUEUE_CAP) begin
                    state_d = ST_REJECT;
                    rej_d   = STAT_QUEUE_FULL;
                end else begin
                    state_d = ST_ASSIGN;
                end
            end
            ST_FLUSH:  state_d = cmd_q.ben ? ST_ASSIGN : ST_REPORT;
            ST_ASSIGN: state_d = cmd_q.kill ? ST_REPORT : ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rej_q   <= STAT_NONE;
            cmd_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            rej_q   <= rej_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                cmd_q.addr <= build_list_addr(cmd_word0, cmd_hibyte);
                cmd_q.kill <= cmd_hibyte[KILL_POS];
                cmd_q.ben  <= cmd_hibyte[BEN_POS];
                cmd_q.rx   <= cmd_rx;
                line_q     <= cmd_line;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        q_flush    = 1'b0;
        q_push     = 1'b0;
        act_valid  = 1'b0;
        stat_valid = 1'b0;
        stat_code  = STAT_NONE;
        act_kind   = pick_action(cmd_q.rx, tgt_bitstuff);
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_EVAL:   ;
            ST_FLUSH: begin
                q_flush   = 1'b1;
                act_valid = 1'b1;
            end
            ST_ASSIGN: q_push = 1'b1;
            ST_REJECT: begin
                stat_valid = 1'b1;
                stat_code  = rej_q;
            end
            ST_REPORT: begin
                stat_valid = 1'b1;
                stat_code  = STAT_KILL_DONE;
            end
            default: ;
        endcase
    end

    assign lat_line = line_q;
    assign lat_rx   = cmd_q.rx;
    assign q_addr   = cmd_q.addr;

endmodule

// File: rtl/bdl_list_mgr.sv
module bdl_list_mgr
    import bdl_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [LINE_W-1:0]    cmd_line,
    input  logic                 cmd_rx,
    input  logic [15:0]          cmd_word0,
    input  logic [7:0]           cmd_hibyte,
    input  logic [NUM_LINES-1:0] line_bitstuff,
    input  logic                 done_valid,
    input  logic [LINE_W-1:0]    done_line,
    input  logic                 done_rx,
    input  logic [LINE_W-1:0]    sel_line,
    output logic [1:0]           rx_count,
    output logic [17:0]          rx_cur_addr,
    output logic [1:0]           tx_count,
    output logic [17:0]          tx_cur_addr,
    output logic                 act_valid,
    output logic [LINE_W-1:0]    act_line,
    output logic                 act_rx,
    output logic [1:0]           act_kind,
    output logic                 stat_valid,
    output logic [LINE_W-1:0]    stat_line,
    output logic                 stat_rx,
    output logic [1:0]           stat_code
);

    localparam int NDIR = 2;

    logic [QCNT_W-1:0]  cnt_arr  [NUM_LINES][NDIR];
    logic [LIST_AW-1:0] head_arr [NUM_LINES][NDIR];

    logic [LINE_W-1:0]  lat_line;
    logic               lat_rx;
    logic               q_flush, q_push;
    logic [LIST_AW-1:0] q_addr;
    logic [QCNT_W-1:0]  tgt_count;
    logic               tgt_bitstuff;
    kill_act_t          fsm_act;
    stat_code_t         fsm_stat;

    assign tgt_count    = cnt_arr[lat_line][lat_rx];
    assign tgt_bitstuff = line_bitstuff[lat_line];

    bdl_cmd_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_line     (cmd_line),
        .cmd_rx       (cmd_rx),
        .cmd_word0    (cmd_word0),
        .cmd_hibyte   (cmd_hibyte),
        .tgt_count    (tgt_count),
        .tgt_bitstuff (tgt_bitstuff),
        .cmd_ready    (cmd_ready),
        .lat_line     (lat_line),
        .lat_rx       (lat_rx),
        .q_flush      (q_flush),
        .q_push       (q_push),
        .q_addr       (q_addr),
        .act_valid    (act_valid),
        .act_kind     (fsm_act),
        .stat_valid   (stat_valid),
        .stat_code    (fsm_stat)
    );

    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        for (genvar dr = 0; dr < NDIR; dr++) begin : g_dir
            logic hit_cmd, hit_done;
            assign hit_cmd  = (lat_line == LINE_W'(ln)) && (lat_rx == 1'(dr));
            assign hit_done = done_valid && (done_line == LINE_W'(ln)) && (done_rx == 1'(dr));
            bdl_queue #(.AW(LIST_AW)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (q_flush && hit_cmd),
                .push      (q_push && hit_cmd),
                .push_addr (q_addr),
                .pop       (hit_done),
                .count     (cnt_arr[ln][dr]),
                .head      (head_arr[ln][dr])
            );
        end
    end

    assign rx_count    = cnt_arr[sel_line][1];
    assign rx_cur_addr = head_arr[sel_line][1];
    assign tx_count    = cnt_arr[sel_line][0];
    assign tx_cur_addr = head_arr[sel_line][0];

    assign act_line  = lat_line;
    assign act_rx    = lat_rx;
    assign act_kind  = fsm_act;
    assign stat_line = lat_line;
    assign stat_rx   = lat_rx;
    assign stat_code = fsm_stat;

endmodule

// File: rtl/bdl_list_mgr_chk.sv
module bdl_list_mgr_chk #(
    parameter int NUM_LINES = 16,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done_valid,
    input logic [LINE_W-1:0] done_line,
    input logic              done_rx,
    input logic [LINE_W-1:0] sel_line,
    input logic [1:0]        rx_count,
    input logic [1:0]        tx_count,
    input logic              act_valid,
    input logic              act_rx,
    input logic [1:0]        act_kind,
    input logic              stat_valid,
    input logic [1:0]        stat_code
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count != 2'd3 && tx_count != 2'd3);

    // R7
    rx_kill_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && act_rx |-> !act_kind[1]);

    // R8
    tx_kill_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_rx |-> act_kind[1]);

    // R9
    stat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R9
    kill_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> !stat_valid || stat_code == 2'd1);

    // R9
    act_stat_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_valid && stat_valid));

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R10
    pop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_rx && done_line == sel_line && rx_count != 2'd0 && cmd_ready
        |=> (sel_line != $past(sel_line)) || (rx_count == $past(rx_count) - 2'd1));

endmodule

bind bdl_list_mgr bdl_list_mgr_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .done_valid (done_valid),
    .done_line  (done_line),
    .done_rx    (done_rx),
    .sel_line   (sel_line),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .act_valid  (act_valid),
    .act_rx     (act_rx),
    .act_kind   (act_kind),
    .stat_valid (stat_valid),
    .stat_code  (stat_code)
);

// File: tb/tb_bdl_list_mgr.sv
module tb_bdl_list_mgr;

    localparam int NL = 16;
    localparam int LW = 4;
    localparam int NV = 13;

    // line[49:46] rx[45] kill[44] ben[43] addr[42:25] code[24:23] cnt[22:21] head[20:3] actv[2] act[1:0]
    localparam logic [49:0] VEC [NV] = '{
        {4'd3, 1'b1, 1'b0, 1'b0, 18'h00100, 2'd0, 2'd1, 18'h00100, 1'b0, 2'd0},
        {4'd3, 1'b1, 1'b0, 1'b0, 18'h2ABCE, 2'd0, 2'd2, 18'h00100, 1'b0, 2'd0},
        {4'd3, 1'b1, 1'b0, 1'b0, 18'h00200, 2'd2, 2'd2, 18'h00100, 1'b0, 2'd0},
        {4'd3, 1'b1, 1'b0, 1'b0, 18'h00301, 2'd3, 2'd2, 18'h00100, 1'b0, 2'd0},
        {4'd3, 1'b0, 1'b0, 1'b0, 18'h10004, 2'd0, 2'd1, 18'h10004, 1'b0, 2'd0},
        {4'd3, 1'b0, 1'b0, 1'b1, 18'h10008, 2'd0, 2'd2, 18'h10004, 1'b0, 2'd0},
        {4'd3, 1'b1, 1'b1, 1'b0, 18'h00005, 2'd1, 2'd0, 18'h00000, 1'b1, 2'd1},
        {4'd3, 1'b0, 1'b1, 1'b1, 18'h3FFFE, 2'd1, 2'd1, 18'h3FFFE, 1'b1, 2'd3},
        {4'd5, 1'b1, 1'b1, 1'b0, 18'h00000, 2'd1, 2'd0, 18'h00000, 1'b1, 2'd0},
        {4'd5, 1'b0, 1'b1, 1'b0, 18'h00000, 2'd1, 2'd0, 18'h00000, 1'b1, 2'd2},
        {4'd5, 1'b0, 1'b0, 1'b0, 18'h00020, 2'd0, 2'd1, 18'h00020, 1'b0, 2'd0},
        {4'd5, 1'b0, 1'b1, 1'b1, 18'h00011, 2'd3, 2'd1, 18'h00020, 1'b0, 2'd0},
        {4'd0, 1'b1, 1'b0, 1'b0, 18'h00000, 2'd0, 2'd1, 18'h00000, 1'b0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [LW-1:0] cmd_line = '0;
    logic          cmd_rx = 1'b0;
    logic [15:0]   cmd_word0 = '0;
    logic [7:0]    cmd_hibyte = '0;
    logic [NL-1:0] line_bitstuff = 16'h0008;
    logic          done_valid = 1'b0;
    logic [LW-1:0] done_line = '0;
    logic          done_rx = 1'b0;
    logic [LW-1:0] sel_line = '0;
    logic [1:0]    rx_count, tx_count;
    logic [17:0]   rx_cur_addr, tx_cur_addr;
    logic          act_valid;
    logic [LW-1:0] act_line;
    logic          act_rx;
    logic [1:0]    act_kind;
    logic          stat_valid;
    logic [LW-1:0] stat_line;
    logic          stat_rx;
    logic [1:0]    stat_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic          seen_stat, seen_act;
    logic [1:0]    seen_code, seen_kind;
    logic [LW-1:0] seen_sline, seen_aline;
    logic          seen_srx, seen_arx;

    always #5 clk = ~clk;

    bdl_list_mgr #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_line(cmd_line), .cmd_rx(cmd_rx), .cmd_word0(cmd_word0), .cmd_hibyte(cmd_hibyte),
        .line_bitstuff(line_bitstuff), .done_valid(done_valid), .done_line(done_line),
        .done_rx(done_rx), .sel_line(sel_line), .rx_count(rx_count), .rx_cur_addr(rx_cur_addr),
        .tx_count(tx_count), .tx_cur_addr(tx_cur_addr), .act_valid(act_valid),
        .act_line(act_line), .act_rx(act_rx), .act_kind(act_kind), .stat_valid(stat_valid),
        .stat_line(stat_line), .stat_rx(stat_rx), .stat_code(stat_code)
    );

    always @(negedge clk) begin
        if (stat_valid) begin
            seen_stat  = 1'b1;
            seen_code  = stat_code;
            seen_sline = stat_line;
            seen_srx   = stat_rx;
        end
        if (act_valid) begin
            seen_act   = 1'b1;
            seen_kind  = act_kind;
            seen_aline = act_line;
            seen_arx   = act_rx;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [LW-1:0] ln, input logic rx, input logic kill,
                         input logic ben, input logic [17:0] addr);
        @(negedge clk);
        seen_stat = 1'b0;
        seen_act  = 1'b0;
        cmd_line   = ln;
        cmd_rx     = rx;
        cmd_word0  = addr[15:0];
        cmd_hibyte = {addr[17:16], ben, kill, 4'b0000};
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic finish_list(input logic [LW-1:0] ln, input logic rx);
        @(negedge clk);
        done_line  = ln;
        done_rx    = rx;
        done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        seen_stat = 1'b0;
        seen_act  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "cmd_ready", 32'(cmd_ready), 1);
        chk("R11", "stat seen", 32'(seen_stat), 0);
        chk("R11", "act seen", 32'(seen_act), 0);
        for (int l = 0; l < NL; l += 5) begin
            sel_line = LW'(l);
            #1;
            chk("R11", "rx_count", 32'(rx_count), 0);
            chk("R11", "tx_count", 32'(tx_count), 0);
        end

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            logic [LW-1:0] ln;
            logic rx;
            v  = VEC[i];
            ln = v[49:46];
            rx = v[45];
            issue(ln, rx, v[44], v[43], v[42:25]);
            sel_line = ln;
            #1;
            chk("R2/R3/R4/R9", "status code", 32'(seen_stat ? seen_code : 2'd0), 32'(v[24:23]));
            if (v[24:23] != 2'd0) begin
                chk("R9", "status line", 32'(seen_sline), 32'(ln));
                chk("R9", "status dir", 32'(seen_srx), 32'(rx));
            end
            chk("R5/R6", "count", 32'(rx ? rx_count : tx_count), 32'(v[22:21]));
            if (v[22:21] != 2'd0)
                chk("R1", "current addr", 32'(rx ? rx_cur_addr : tx_cur_addr), 32'(v[20:3]));
            chk("R4", "action seen", 32'(seen_act), 32'(v[2]));
            if (v[2]) begin
                chk("R7/R8", "action kind", 32'(seen_kind), 32'(v[1:0]));
                chk("R7/R8", "action line", 32'(seen_aline), 32'(ln));
                chk("R7/R8", "action dir", 32'(seen_arx), 32'(rx));
            end
            if (i == 6) chk("R5", "other direction kept", 32'(tx_count), 2);
        end

        // R10 pop of a single entry
        finish_list(4'd3, 1'b0);
        sel_line = 4'd3;
        #1;
        chk("R10", "pop to empty", 32'(tx_count), 0);

        // R10 pop exposes the second entry
        issue(4'd0, 1'b1, 1'b0, 1'b0, 18'h00040);
        finish_list(4'd0, 1'b1);
        sel_line = 4'd0;
        #1;
        chk("R10", "count after pop", 32'(rx_count), 1);
        chk("R10", "next becomes current", 32'(rx_cur_addr), 32'h00040);

        // R10 pop of an empty queue
        finish_list(4'd3, 1'b0);
        sel_line = 4'd3;
        #1;
        chk("R10", "empty pop tx", 32'(tx_count), 0);
        chk("R10", "empty pop rx", 32'(rx_count), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule